// File: doc/BRIEF.md
# DRAM Current-Test Command Sequencer

This block is a stimulus source for measuring supply current of a DRAM rank with eight banks. It does not serve memory requests. Instead, it loops a fixed command pattern chosen by a mode input, for as long as a run input stays high. The patterns cover several cases: an open/close loop on one bank, the same loop with a column read inside it, standby and power-down with all banks closed or all open, interleaved burst reads or writes across the banks, back-to-back refresh, and a rotation of activate plus read-with-auto-precharge across the banks. Every spacing between commands comes from a programmable cycle count.

A command is issued on a cycle of its own. The next command follows exactly "gap" cycles later, and NOP fills the cycles in between. Each pattern is a short list of commands that forms one iteration. A change of mode or a drop of the run input is acted on only when an iteration finishes. The block then issues a precharge-all before it enters the new pattern or returns to idle. An iteration counter lets a bench line the command trace up against the expected timing.

Top module: `ddr_itest_seq`

## Requirements
- R1: After reset, and while idle with run low, the command is NOP (code 0), clock enable is high, the iteration count is 0, and all address and data outputs are zero.
- R2: When run is seen high in idle, the count clears and precharge-all (code 3) follows one cycle later. Every precharge-all is followed by a wait of t_rp. A precharge-all issued with run low returns the block to idle.
- R3: Mode 0 repeats ACT (code 1) on bank 0 at the test row, then PRE (code 2) t_ras later, with the next ACT t_rp after the PRE.
- R4: Mode 1 repeats ACT on bank 0, then RD (code 4) of column 0 t_rcd later, then PRE max(t_ras−t_rcd,1) after the RD, then waits t_rp.
- R5: Modes 2 and 3 close all banks (mode 2) or also open banks 0 to 7 in order (mode 3). They then issue NOP with clock enable high, one iteration per cycle. Mode values 10 to 15 behave as mode 2.
- R6: Modes 4 and 5 use the same setup as modes 2 and 3, then hold clock enable low while issuing NOP, one iteration per cycle. Clock enable is low on no other command.
- R7: Modes 6 and 7 open banks 0 to 7 with ACT spaced t_rrd. The spacing after the last ACT is t_rcd. The block then issues RD (mode 6) or WR (code 6) every BURST_GAP cycles, starting at bank 0 and column 0, moving to the next bank after each access. The column advances by COL_STEP each time the bank wraps from 7 to 0.
- R8: Write data is 0 on the first WR after setup and alternates with the byte 0x33 repeated across the data width on each later WR. Data is zero on every other command.
- R9: Mode 8 issues REF (code 7) every t_rfc cycles.
- R10: Mode 9 issues ACT to bank b, then RDA (code 5) of column 0 to the same bank t_rcd later. The next ACT, to bank b+1 modulo 8, follows max(t_rrd−t_rcd,1) after the RDA. b starts at 0.
- R11: A timing input of 0 acts as 1, and a gap of 1 gives back-to-back commands.
- R12: A change of mode is acted on only at the last command of an iteration. That command is followed by precharge-all and then the new mode's setup.
- R13: The iteration count increments in the cycle the last command of an iteration appears, and all fields a command does not use are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Start when high, stop at iteration end when low |
| mode_i | input | 4 | Test pattern select |
| t_ras_i | input | TW | Activate-to-precharge cycles |
| t_rp_i | input | TW | Precharge-to-activate cycles |
| t_rcd_i | input | TW | Activate-to-column cycles |
| t_rfc_i | input | TW | Refresh-to-refresh cycles |
| t_rrd_i | input | TW | Activate-to-activate cycles |
| cmd_o | output | 3 | Command code |
| bank_o | output | BANK_W | Bank address |
| row_o | output | ROW_W | Row address, valid with ACT |
| col_o | output | COL_W | Column address |
| wdata_o | output | DATA_W | Write data pattern, valid with WR |
| cke_o | output | 1 | Clock enable |
| iter_o | output | ITER_W | Completed iteration count |

## Verification
A wrong phase or step register usually shows up within one command slot. The port then carries a command of the wrong type, or a NOP where a command was due. A gap counter that is off by one shifts the next non-NOP command by a cycle, and the cycle-exact comparison catches it at that slot. Errors in the bank, column or data-phase state stay hidden until the next access in a burst or rotation mode, which is at most BURST_GAP or one rotation step away. A wrong decision at the end of an iteration shows up as a missing or extra precharge-all and an iteration count that drifts.

// File: rtl/itest_pkg.sv
`timescale 1ns/1ps
package itest_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_PRE  = 3'd2,
    CMD_PREA = 3'd3,
    CMD_RD   = 3'd4,
    CMD_RDA  = 3'd5,
    CMD_WR   = 3'd6,
    CMD_REF  = 3'd7
  } itest_cmd_e;

  typedef enum logic [1:0] {PH_IDLE, PH_CLOSE, PH_SETUP, PH_LOOP} itest_phase_e;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_ACT_PRE    = 4'd0;
  localparam logic [MODE_W-1:0] MD_ACT_RD_PRE = 4'd1;
  localparam logic [MODE_W-1:0] MD_PRE_STBY   = 4'd2;
  localparam logic [MODE_W-1:0] MD_ACT_STBY   = 4'd3;
  localparam logic [MODE_W-1:0] MD_PRE_PDN    = 4'd4;
  localparam logic [MODE_W-1:0] MD_ACT_PDN    = 4'd5;
  localparam logic [MODE_W-1:0] MD_BURST_RD   = 4'd6;
  localparam logic [MODE_W-1:0] MD_BURST_WR   = 4'd7;
  localparam logic [MODE_W-1:0] MD_REFRESH    = 4'd8;
  localparam logic [MODE_W-1:0] MD_ACT_RDA    = 4'd9;

  function automatic logic opens_all(input logic [MODE_W-1:0] m);
    return (m == MD_ACT_STBY) || (m == MD_ACT_PDN) ||
           (m == MD_BURST_RD) || (m == MD_BURST_WR);
  endfunction

  function automatic logic is_pdn(input logic [MODE_W-1:0] m);
    return (m == MD_PRE_PDN) || (m == MD_ACT_PDN);
  endfunction
endpackage

// File: rtl/itest_gap_timer.sv
`timescale 1ns/1ps
module itest_gap_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] gap,
  output logic          ready
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= gap - 1'b1;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/itest_addr_gen.sv
`timescale 1ns/1ps
module itest_addr_gen #(
  parameter int BANKS    = 8,
  parameter int BANK_W   = 3,
  parameter int COL_W    = 10,
  parameter int COL_STEP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv_bank,
  input  logic              col_en,
  input  logic              flip,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  col,
  output logic              phase
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(BANKS - 1);
  localparam logic [COL_W-1:0]  COL_INC   = COL_W'(COL_STEP);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bank  <= '0;
      col   <= '0;
      phase <= 1'b0;
    end else begin
      if (adv_bank) begin
        if (bank == LAST_BANK) begin
          bank <= '0;
          if (col_en) col <= col + COL_INC;
        end else begin
          bank <= bank + 1'b1;
        end
      end
      if (flip) phase <= ~phase;
    end
  end
endmodule

// File: rtl/ddr_itest_seq.sv
`timescale 1ns/1ps
module ddr_itest_seq import itest_pkg::*; #(
  parameter int TW        = 8,
  parameter int BANKS     = 8,
  parameter int BANK_W    = $clog2(BANKS),
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 16,
  parameter int ITER_W    = 16,
  parameter int BURST_GAP = 4,
  parameter int COL_STEP  = 8,
  parameter logic [ROW_W-1:0] TEST_ROW = 'h0A5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TW-1:0]     t_ras_i,
  input  logic [TW-1:0]     t_rp_i,
  input  logic [TW-1:0]     t_rcd_i,
  input  logic [TW-1:0]     t_rfc_i,
  input  logic [TW-1:0]     t_rrd_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              cke_o,
  output logic [ITER_W-1:0] iter_o
);
  localparam logic [TW-1:0]     ONE       = TW'(1);
  localparam logic [TW-1:0]     BGAP      = TW'(BURST_GAP);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(BANKS - 1);
  localparam logic [DATA_W-1:0] PAT_HI    = {(DATA_W/8){8'h33}};

  // timing values with zero treated as one
  logic [TW-1:0] ras_e, rp_e, rcd_e, rfc_e, rrd_e, rd_gap, rda_gap;
  assign ras_e   = (t_ras_i == '0) ? ONE : t_ras_i;
  assign rp_e    = (t_rp_i  == '0) ? ONE : t_rp_i;
  assign rcd_e   = (t_rcd_i == '0) ? ONE : t_rcd_i;
  assign rfc_e   = (t_rfc_i == '0) ? ONE : t_rfc_i;
  assign rrd_e   = (t_rrd_i == '0) ? ONE : t_rrd_i;
  assign rd_gap  = (ras_e > rcd_e) ? (ras_e - rcd_e) : ONE;
  assign rda_gap = (rrd_e > rcd_e) ? (rrd_e - rcd_e) : ONE;

  itest_phase_e      ph_q, ph_n;
  logic [1:0]        step_q, step_n;
  logic [MODE_W-1:0] mode_q, mode_n;
  logic [ITER_W-1:0] iter_n;

  logic              go, load, clr, adv, col_en, flip, last;
  logic [TW-1:0]     gap;
  logic [BANK_W-1:0] ag_bank;
  logic [COL_W-1:0]  ag_col;
  logic              ag_phase;

  itest_cmd_e        n_cmd;
  logic [BANK_W-1:0] n_bank;
  logic [ROW_W-1:0]  n_row;
  logic [COL_W-1:0]  n_col;
  logic [DATA_W-1:0] n_wd;
  logic              n_cke;

  itest_gap_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst(rst), .load(load), .gap(gap), .ready(go)
  );

  itest_addr_gen #(
    .BANKS(BANKS), .BANK_W(BANK_W), .COL_W(COL_W), .COL_STEP(COL_STEP)
  ) addr_i (
    .clk(clk), .rst(rst), .clr(clr), .adv_bank(adv), .col_en(col_en),
    .flip(flip), .bank(ag_bank), .col(ag_col), .phase(ag_phase)
  );

  always_comb begin
    n_cmd  = CMD_NOP;
    n_bank = '0;
    n_row  = '0;
    n_col  = '0;
    n_wd   = '0;
    n_cke  = 1'b1;
    load   = 1'b0;
    gap    = ONE;
    clr    = 1'b0;
    adv    = 1'b0;
    col_en = 1'b0;
    flip   = 1'b0;
    last   = 1'b0;
    ph_n   = ph_q;
    step_n = step_q;
    mode_n = mode_q;
    iter_n = iter_o;
    if (go) begin
      case (ph_q)
        PH_IDLE: begin
          if (run_i) begin
            ph_n   = PH_CLOSE;
            iter_n = '0;
          end
        end
        PH_CLOSE: begin
          n_cmd  = CMD_PREA;
          load   = 1'b1;
          gap    = rp_e;
          clr    = 1'b1;
          step_n = 2'd0;
          if (!run_i) begin
            ph_n = PH_IDLE;
          end else begin
            mode_n = mode_i;
            ph_n   = opens_all(mode_i) ? PH_SETUP : PH_LOOP;
          end
        end
        PH_SETUP: begin
          n_cmd  = CMD_ACT;
          n_bank = ag_bank;
          n_row  = TEST_ROW;
          load   = 1'b1;
          adv    = 1'b1;
          gap    = (ag_bank == LAST_BANK) ? rcd_e : rrd_e;
          if (ag_bank == LAST_BANK) ph_n = PH_LOOP;
        end
        default: begin
          load = 1'b1;
          case (mode_q)
            MD_ACT_PRE: begin
              if (step_q == 2'd0) begin
                n_cmd  = CMD_ACT;
                n_row  = TEST_ROW;
                gap    = ras_e;
                step_n = 2'd1;
              end else begin
                n_cmd = CMD_PRE;
                gap   = rp_e;
                last  = 1'b1;
              end
            end
            MD_ACT_RD_PRE: begin
              if (step_q == 2'd0) begin
                n_cmd  = CMD_ACT;
                n_row  = TEST_ROW;
                gap    = rcd_e;
                step_n = 2'd1;
              end else if (step_q == 2'd1) begin
                n_cmd  = CMD_RD;
                gap    = rd_gap;
                step_n = 2'd2;
              end else begin
                n_cmd = CMD_PRE;
                gap   = rp_e;
                last  = 1'b1;
              end
            end
            MD_BURST_RD, MD_BURST_WR: begin
              n_cmd  = (mode_q == MD_BURST_WR) ? CMD_WR : CMD_RD;
              n_bank = ag_bank;
              n_col  = ag_col;
              n_wd   = ((mode_q == MD_BURST_WR) && ag_phase) ? PAT_HI : '0;
              flip   = (mode_q == MD_BURST_WR);
              gap    = BGAP;
              adv    = 1'b1;
              col_en = 1'b1;
              last   = 1'b1;
            end
            MD_REFRESH: begin
              n_cmd = CMD_REF;
              gap   = rfc_e;
              last  = 1'b1;
            end
            MD_ACT_RDA: begin
              n_bank = ag_bank;
              if (step_q == 2'd0) begin
                n_cmd  = CMD_ACT;
                n_row  = TEST_ROW;
                gap    = rcd_e;
                step_n = 2'd1;
              end else begin
                n_cmd = CMD_RDA;
                gap   = rda_gap;
                adv   = 1'b1;
                last  = 1'b1;
              end
            end
            default: begin
              n_cke = ~is_pdn(mode_q);
              last  = 1'b1;
            end
          endcase
          if (last) begin
            iter_n = iter_o + 1'b1;
            step_n = 2'd0;
            if (!run_i || (mode_i != mode_q)) ph_n = PH_CLOSE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      step_q  <= 2'd0;
      mode_q  <= '0;
      iter_o  <= '0;
      cmd_o   <= CMD_NOP;
      bank_o  <= '0;
      row_o   <= '0;
      col_o   <= '0;
      wdata_o <= '0;
      cke_o   <= 1'b1;
    end else begin
      ph_q    <= ph_n;
      step_q  <= step_n;
      mode_q  <= mode_n;
      iter_o  <= iter_n;
      cmd_o   <= n_cmd;
      bank_o  <= n_bank;
      row_o   <= n_row;
      col_o   <= n_col;
      wdata_o <= n_wd;
      cke_o   <= n_cke;
    end
  end
endmodule

// File: rtl/itest_seq_chk.sv
`timescale 1ns/1ps
module itest_seq_chk import itest_pkg::*; #(
  parameter int TW     = 8,
  parameter int BANKS  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int ITER_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [TW-1:0]     t_rp_i,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [ROW_W-1:0]  row_o,
  input logic [COL_W-1:0]  col_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              cke_o,
  input logic [ITER_W-1:0] iter_o
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(BANKS - 1);

  logic [BANK_W-1:0] wr_prev, act_prev, wr_next;
  logic              wr_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev  <= '0;
      act_prev <= '0;
      wr_seen  <= 1'b0;
    end else begin
      if (cmd_o == CMD_PREA) wr_seen <= 1'b0;
      if (cmd_o == CMD_WR) begin
        wr_seen <= 1'b1;
        wr_prev <= bank_o;
      end
      if (cmd_o == CMD_ACT) act_prev <= bank_o;
    end
  end

  assign wr_next = (wr_prev == LAST_BANK) ? '0 : wr_prev + 1'b1;

  a_r6_cke_low_only_nop: assert property (@(posedge clk) disable iff (rst)
    !cke_o |-> cmd_o == CMD_NOP);

  a_r13_nop_fields_zero: assert property (@(posedge clk) disable iff (rst)
    cmd_o == CMD_NOP |-> (bank_o == '0 && row_o == '0 && col_o == '0 && wdata_o == '0));

  a_r8_data_only_on_write: assert property (@(posedge clk) disable iff (rst)
    cmd_o != CMD_WR |-> wdata_o == '0);

  a_r13_iter_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (iter_o == $past(iter_o) || iter_o == $past(iter_o) + 1'b1 || iter_o == '0));

  a_r2_prea_waits_trp: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_PREA && $past(t_rp_i) > 1) |=> cmd_o == CMD_NOP);

  a_r7_write_bank_rotates: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_WR && wr_seen) |-> bank_o == wr_next);

  a_r10_rda_same_bank: assert property (@(posedge clk) disable iff (rst)
    cmd_o == CMD_RDA |-> bank_o == act_prev);
endmodule

bind ddr_itest_seq itest_seq_chk #(
  .TW(TW), .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
  .COL_W(COL_W), .DATA_W(DATA_W), .ITER_W(ITER_W)
) chk_i (
  .clk(clk), .rst(rst), .t_rp_i(t_rp_i), .cmd_o(cmd_o), .bank_o(bank_o),
  .row_o(row_o), .col_o(col_o), .wdata_o(wdata_o), .cke_o(cke_o), .iter_o(iter_o)
);

// File: tb/ddr_itest_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_itest_seq_tb_top;
  import itest_pkg::*;

  localparam int TW = 8, BANK_W = 3, ROW_W = 14, COL_W = 10, DATA_W = 16, ITER_W = 16;
  localparam int BURST_GAP = 4, COL_STEP = 8, TEST_ROW = 'h0A5, PAT_HI = 'h3333;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0;
  logic [3:0] mode = 4'd0;
  logic [TW-1:0] tras = 8'd5, trp = 8'd3, trcd = 8'd2, trfc = 8'd6, trrd = 8'd3;
  logic [2:0] cmd_o;
  logic [BANK_W-1:0] bank_o;
  logic [ROW_W-1:0] row_o;
  logic [COL_W-1:0] col_o;
  logic [DATA_W-1:0] wdata_o;
  logic cke_o;
  logic [ITER_W-1:0] iter_o;

  always #5 clk = ~clk;

  ddr_itest_seq dut_i (
    .clk(clk), .rst(rst), .run_i(run), .mode_i(mode),
    .t_ras_i(tras), .t_rp_i(trp), .t_rcd_i(trcd), .t_rfc_i(trfc), .t_rrd_i(trrd),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .wdata_o(wdata_o), .cke_o(cke_o), .iter_o(iter_o)
  );

  int errors = 0, checks = 0;
  int e_cmd = 0, e_bank = 0, e_row = 0, e_col = 0, e_wd = 0, e_cke = 1, e_iter = 0;
  string e_req = "R1", tag_ovr = "";
  bit model_on = 1'b0, cap_run = 1'b0;
  int cap_mode = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic set_out(int c, int b, int r, int co, int d, int k);
    e_cmd = c; e_bank = b; e_row = r; e_col = co; e_wd = d; e_cke = k;
  endtask

  // called at an edge where the design issues a command; returns at the next issuing edge
  task automatic issue(int c, int b, int r, int co, int d, int k, int g, bit last, string req);
    cap_run  = run;
    cap_mode = int'(mode);
    #1;
    set_out(c, b, r, co, d, k);
    e_req = (tag_ovr != "") ? tag_ovr : req;
    if (last) e_iter = (e_iter + 1) % 65536;
    for (int i = 1; i < g; i++) begin
      @(posedge clk);
      #1;
      set_out(0, 0, 0, 0, 0, 1);
    end
    @(posedge clk);
  endtask

  initial begin : ref_model
    int m, b, c, dp;
    wait (rst == 1'b0);
    @(posedge clk);
    forever begin
      if (!run) begin
        #1; set_out(0, 0, 0, 0, 0, 1); e_req = "R1";
        @(posedge clk);
      end else begin
        #1; set_out(0, 0, 0, 0, 0, 1); e_iter = 0; e_req = "R2";
        @(posedge clk);
        forever begin
          issue(int'(CMD_PREA), 0, 0, 0, 0, 1, eff(trp), 1'b0, "R2/R12");
          if (!cap_run) break;
          m = cap_mode; b = 0; c = 0; dp = 0;
          if (m == 3 || m == 5 || m == 6 || m == 7)
            for (int k = 0; k < 8; k++)
              issue(int'(CMD_ACT), k, TEST_ROW, 0, 0, 1, (k == 7) ? eff(trcd) : eff(trrd),
                    1'b0, (m >= 6) ? "R7" : "R5");
          forever begin
            case (m)
              0: begin
                issue(int'(CMD_ACT), 0, TEST_ROW, 0, 0, 1, eff(tras), 1'b0, "R3");
                issue(int'(CMD_PRE), 0, 0, 0, 0, 1, eff(trp), 1'b1, "R3");
              end
              1: begin
                issue(int'(CMD_ACT), 0, TEST_ROW, 0, 0, 1, eff(trcd), 1'b0, "R4");
                issue(int'(CMD_RD), 0, 0, 0, 0, 1,
                      (eff(tras) > eff(trcd)) ? eff(tras) - eff(trcd) : 1, 1'b0, "R4");
                issue(int'(CMD_PRE), 0, 0, 0, 0, 1, eff(trp), 1'b1, "R4");
              end
              4, 5: issue(int'(CMD_NOP), 0, 0, 0, 0, 0, 1, 1'b1, "R6");
              6, 7: begin
                issue((m == 7) ? int'(CMD_WR) : int'(CMD_RD), b, 0, c,
                      (m == 7 && dp == 1) ? PAT_HI : 0, 1, BURST_GAP, 1'b1,
                      (m == 7) ? "R8" : "R7");
                if (m == 7) dp = 1 - dp;
                b = (b + 1) % 8;
                if (b == 0) c = (c + COL_STEP) % 1024;
              end
              8: issue(int'(CMD_REF), 0, 0, 0, 0, 1, eff(trfc), 1'b1, "R9");
              9: begin
                issue(int'(CMD_ACT), b, TEST_ROW, 0, 0, 1, eff(trcd), 1'b0, "R10");
                issue(int'(CMD_RDA), b, 0, 0, 0, 1,
                      (eff(trrd) > eff(trcd)) ? eff(trrd) - eff(trcd) : 1, 1'b1, "R10");
                b = (b + 1) % 8;
              end
              default: issue(int'(CMD_NOP), 0, 0, 0, 0, 1, 1, 1'b1, "R5");
            endcase
            if (!cap_run || cap_mode != m) break;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(e_req, "cmd", int'(cmd_o), e_cmd);
      chk(e_req, "bank", int'(bank_o), e_bank);
      chk(e_req, "row", int'(row_o), e_row);
      chk(e_req, "col", int'(col_o), e_col);
      chk(e_req, "wdata", int'(wdata_o), e_wd);
      chk(e_req, "cke", int'(cke_o), e_cke);
      chk("R13", "iter", int'(iter_o), e_iter);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin : stimulus
    wait_cyc(3);
    chk("R1", "reset cmd", int'(cmd_o), 0);
    chk("R1", "reset cke", int'(cke_o), 1);
    chk("R1", "reset iter", int'(iter_o), 0);
    rst = 1'b0;
    model_on = 1'b1;
    wait_cyc(5);
    // walk through every mode; R12 covers each switch
    run = 1'b1; mode = 4'd0; wait_cyc(60);
    mode = 4'd1;  wait_cyc(60);
    mode = 4'd2;  wait_cyc(20);
    mode = 4'd3;  wait_cyc(60);
    mode = 4'd4;  wait_cyc(20);
    mode = 4'd5;  wait_cyc(60);
    mode = 4'd6;  wait_cyc(200);
    mode = 4'd7;  wait_cyc(200);
    mode = 4'd8;  wait_cyc(60);
    mode = 4'd9;  wait_cyc(90);
    mode = 4'd12; wait_cyc(20);
    run = 1'b0;   wait_cyc(40);
    // R11: zero timing values act as one
    tag_ovr = "R11";
    tras = 0; trp = 0; trcd = 0; trfc = 0; trrd = 0;
    run = 1'b1; mode = 4'd0; wait_cyc(30);
    mode = 4'd1; wait_cyc(30);
    mode = 4'd9; wait_cyc(40);
    mode = 4'd7; wait_cyc(70);
    mode = 4'd8; wait_cyc(20);
    run = 1'b0; wait_cyc(20);
    tag_ovr = "";
    // R2: stop requested in the middle of a long iteration
    tras = 9; trp = 4; trcd = 5; trfc = 25; trrd = 2;
    run = 1'b1; mode = 4'd8; wait_cyc(12);
    run = 1'b0; wait_cyc(60);
    run = 1'b1; mode = 4'd1; wait_cyc(50);
    mode = 4'd9; wait_cyc(60);
    run = 1'b0; wait_cyc(40);
    finish_run();
  end
endmodule